// File: doc/BRIEF.md
# Four-Way Virtually Indexed Cache Lookup Array

This block holds the directory and the line storage of a 32 KB, four-way set-associative cache. It has 256 sets. Each line holds eight 32-bit words. The set is chosen from virtual address bits. A translation unit outside the block supplies the physical address, and the upper physical bits are compared with the tag stored in each way. A lookup reports which way hit, the addressed word, whether that line is dirty, and the way a refill would replace.

The surrounding core uses four strobes:

- **Read** performs a lookup and registers the result one clock later.
- **Write** updates one word of a line that hits.
- **Fill** commits a whole line, with its tag, into the victim way in one cycle.
- **Policy input** selects copy-back or write-through. It decides whether a store marks the line dirty.

There are two reset inputs. Power-on reset clears the valid bits, the dirty bits and the replacement state. Manual reset clears only the registered lookup outputs and leaves the cache contents in place.

Top module: `vcache_vipt`

## Requirements
- R1: The set index is vAddr[12:5] and the word within the line is vAddr[4:2]. The tag compared and stored is pAddr[28:10]. Fill word k sits at fillLine[32k+31:32k].
- R2: The lookup results (hitWay, miss, rdData, victimWay, hitDirty) are registered on the clock edge that samples rdEn=1. They hold their value while rdEn is 0.
- R3: hitWay bit w is 1 when way w of the indexed set is valid and its stored tag equals pAddr[28:10]. At most one bit is set. miss is 1 when no way hits, and rdData is then 0.
- R4: A fill writes all eight words, loads the tag, sets the valid bit and clears the dirty bit of the victim way. It also makes that way most recent. All of this happens on one clock edge.
- R5: Power-on reset (porRstN=0) clears every valid bit, every dirty bit and every replacement field, and zeroes the outputs. After it, every lookup misses with victimWay 0.
- R6: Manual reset (manRstN=0) zeroes the registered outputs only. Valid bits, dirty bits, tags, data and replacement state are kept.
- R7: A write that hits stores wrData into the addressed word. With copyBack=1 it sets the line's dirty bit. With copyBack=0 the dirty bit is left unchanged.
- R8: Each set keeps a 6-bit replacement field, one bit per way pair, in the order (0,1),(0,2),(0,3),(1,2),(1,3),(2,3). A bit of 1 means the lower way of the pair was used more recently. A read hit, a write hit or a fill makes the accessed way most recent. When all four ways are valid, victimWay is the way older than the other three.
- R9: When the set has an invalid way, victimWay is the lowest-numbered invalid way.
- R10: When fill, read and write fall in the same cycle, the read reports the state before the fill, the write is dropped, and the fill commits.
- R11: A write that misses changes no data, no dirty bit and no replacement state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, active low, synchronous |
| manRstN | input | 1 | Manual reset, active low, synchronous |
| vAddr | input | 11 | Virtual address bits [12:2]: set index and word select |
| pAddr | input | 19 | Physical address bits [28:10] from translation |
| rdEn | input | 1 | Lookup strobe |
| wrEn | input | 1 | Word store strobe |
| wrData | input | 32 | Word to store on a write hit |
| copyBack | input | 1 | 1 = copy-back policy, 0 = write-through |
| fillEn | input | 1 | Line fill commit strobe |
| fillLine | input | 256 | Eight words of the refill line |
| hitWay | output | 4 | Registered per-way hit vector |
| miss | output | 1 | Registered miss flag |
| rdData | output | 32 | Registered selected word |
| victimWay | output | 2 | Registered replacement way for the looked-up set |
| hitDirty | output | 1 | Registered dirty bit of the hitting line |

## Verification
A fill can share its clock edge with a lookup and a store to the same address. The lookup must see the set as it was before the commit, and the store must not corrupt the incoming line. The bench provokes this by raising fillEn, rdEn and wrEn together on an empty set. It expects a miss with victim 0 from that cycle, and then, on a following read, the fill data with the line clean. Replacement order is judged in the same way: miss lookups between hits and stores must return the way that the pair-order rule names.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  localparam int unsigned NUM_WAYS      = 4;
  localparam int unsigned SET_BITS      = 8;
  localparam int unsigned WORD_SEL_BITS = 3;
  localparam int unsigned DATA_W        = 32;
  localparam int unsigned PA_W          = 29;
  localparam int unsigned TAG_LSB       = 10;

  localparam int unsigned NUM_SETS    = 1 << SET_BITS;
  localparam int unsigned LINE_WORDS  = 1 << WORD_SEL_BITS;
  localparam int unsigned LINE_W      = LINE_WORDS * DATA_W;
  localparam int unsigned OFFSET_LSB  = $clog2(DATA_W / 8);
  localparam int unsigned INDEX_LSB   = OFFSET_LSB + WORD_SEL_BITS;
  localparam int unsigned VA_HI       = INDEX_LSB + SET_BITS - 1;
  localparam int unsigned TAG_W       = PA_W - TAG_LSB;
  localparam int unsigned WAY_BITS    = $clog2(NUM_WAYS);
  localparam int unsigned LRU_W       = NUM_WAYS * (NUM_WAYS - 1) / 2;

  typedef logic [WAY_BITS-1:0] wayIdx_t;
  typedef logic [LRU_W-1:0]    lruField_t;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic    lineLoad;
    wayIdx_t loadWay;
    logic    wordStore;
    wayIdx_t storeWay;
    logic    readCapture;
    logic    readHit;
    wayIdx_t readWay;
    logic    outClear;
  } dpCtl_t;

  // Pair bit k walks (i,j), i<j, in lexical order; 1 = i more recent
  function automatic lruField_t lruTouch(lruField_t cur, wayIdx_t way);
    lruField_t nxt;
    int k;
    nxt = cur;
    k = 0;
    for (int i = 0; i < NUM_WAYS - 1; i++) begin
      for (int j = i + 1; j < NUM_WAYS; j++) begin
        if (int'(way) == i) nxt[k] = 1'b1;
        else if (int'(way) == j) nxt[k] = 1'b0;
        k++;
      end
    end
    return nxt;
  endfunction

  function automatic wayIdx_t lruOldest(lruField_t cur);
    wayIdx_t pick;
    pick = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      logic older;
      int k;
      older = 1'b1;
      k = 0;
      for (int i = 0; i < NUM_WAYS - 1; i++) begin
        for (int j = i + 1; j < NUM_WAYS; j++) begin
          if (i == w && cur[k]) older = 1'b0;
          if (j == w && !cur[k]) older = 1'b0;
          k++;
        end
      end
      if (older) pick = wayIdx_t'(w);
    end
    return pick;
  endfunction

endpackage

// File: rtl/vcache_datapath.sv
module vcache_datapath
  import vcache_pkg::*;
(
  input  logic                     clk,
  input  dpCtl_t                   ctl,
  input  logic [SET_BITS-1:0]      setIdx,
  input  logic [WORD_SEL_BITS-1:0] wordSel,
  input  logic [TAG_W-1:0]         tagIn,
  input  logic [LINE_W-1:0]        fillLine,
  input  logic [DATA_W-1:0]        wrWord,
  output logic [NUM_WAYS-1:0]      tagEq,
  output logic [DATA_W-1:0]        rdData
);

  logic [DATA_W-1:0] wayWord [NUM_WAYS];

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    // Tag and line storage carry no reset
    logic [TAG_W-1:0]  tagMem  [NUM_SETS];
    logic [LINE_W-1:0] lineMem [NUM_SETS];

    always_ff @(posedge clk) begin
      if (ctl.lineLoad && ctl.loadWay == wayIdx_t'(w)) begin
        tagMem[setIdx]  <= tagIn;
        lineMem[setIdx] <= fillLine;
      end else if (ctl.wordStore && ctl.storeWay == wayIdx_t'(w)) begin
        lineMem[setIdx][wordSel*DATA_W +: DATA_W] <= wrWord;
      end
    end

    assign tagEq[w]   = (tagMem[setIdx] == tagIn);
    assign wayWord[w] = lineMem[setIdx][wordSel*DATA_W +: DATA_W];
  end

  always_ff @(posedge clk) begin
    if (ctl.outClear)         rdData <= '0;
    else if (ctl.readCapture) rdData <= ctl.readHit ? wayWord[ctl.readWay] : '0;
  end

  // Store and load never target the same edge
  p_store_excl_r10: assert property (@(posedge clk) disable iff (ctl.outClear)
    ctl.wordStore |-> !ctl.lineLoad);

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic                clk,
  input  logic                porRstN,
  input  logic                manRstN,
  input  logic [SET_BITS-1:0] setIdx,
  input  logic                rdEn,
  input  logic                wrEn,
  input  logic                fillEn,
  input  logic                copyBack,
  input  logic [NUM_WAYS-1:0] tagEq,
  output dpCtl_t              ctl,
  output logic [NUM_WAYS-1:0] hitWayQ,
  output logic                missQ,
  output wayIdx_t             victimQ,
  output logic                hitDirtyQ
);

  logic [NUM_SETS-1:0] validArr [NUM_WAYS];
  logic [NUM_SETS-1:0] dirtyArr [NUM_WAYS];
  lruField_t           lruArr   [NUM_SETS];

  logic [NUM_WAYS-1:0] setValid, setDirty, hitVec;
  lruField_t           setLru;
  logic                anyHit, anyFree, doStore, doTouch, outClear;
  wayIdx_t             hitIdx, freeIdx, victim, touchWay;

  always_comb begin
    for (int w = 0; w < NUM_WAYS; w++) begin
      setValid[w] = validArr[w][setIdx];
      setDirty[w] = dirtyArr[w][setIdx];
    end
  end

  assign setLru = lruArr[setIdx];
  assign hitVec = tagEq & setValid;
  assign anyHit = |hitVec;
  assign anyFree = ~&setValid;

  always_comb begin
    hitIdx  = '0;
    freeIdx = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (hitVec[w])    hitIdx  = wayIdx_t'(w);
      if (!setValid[w]) freeIdx = wayIdx_t'(w);
    end
  end

  assign victim   = anyFree ? freeIdx : lruOldest(setLru);
  assign doStore  = wrEn && anyHit && !fillEn;
  assign doTouch  = fillEn || ((rdEn || wrEn) && anyHit);
  assign touchWay = fillEn ? victim : hitIdx;
  assign outClear = !porRstN || !manRstN;

  always_comb begin
    ctl.lineLoad    = fillEn;
    ctl.loadWay     = victim;
    ctl.wordStore   = doStore;
    ctl.storeWay    = hitIdx;
    ctl.readCapture = rdEn;
    ctl.readHit     = anyHit;
    ctl.readWay     = hitIdx;
    ctl.outClear    = outClear;
  end

  // Valid and dirty: cleared only by power-on reset
  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_state
    always_ff @(posedge clk) begin
      if (!porRstN) begin
        validArr[w] <= '0;
        dirtyArr[w] <= '0;
      end else if (fillEn) begin
        if (victim == wayIdx_t'(w)) begin
          validArr[w][setIdx] <= 1'b1;
          dirtyArr[w][setIdx] <= 1'b0;
        end
      end else if (doStore && copyBack && hitIdx == wayIdx_t'(w)) begin
        dirtyArr[w][setIdx] <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!porRstN) begin
      for (int s = 0; s < NUM_SETS; s++) lruArr[s] <= '0;
    end else if (doTouch) begin
      lruArr[setIdx] <= lruTouch(setLru, touchWay);
    end
  end

  always_ff @(posedge clk) begin
    if (outClear) begin
      hitWayQ   <= '0;
      missQ     <= 1'b0;
      victimQ   <= '0;
      hitDirtyQ <= 1'b0;
    end else if (rdEn) begin
      hitWayQ   <= hitVec;
      missQ     <= !anyHit;
      victimQ   <= victim;
      hitDirtyQ <= anyHit && setDirty[hitIdx];
    end
  end

  p_hit_onehot_r3: assert property (@(posedge clk) disable iff (!porRstN)
    $onehot0(hitVec));

  p_fill_commit_r4: assert property (@(posedge clk) disable iff (!porRstN)
    fillEn |=> validArr[$past(victim)][$past(setIdx)] && !dirtyArr[$past(victim)][$past(setIdx)]);

  p_out_clear_r6: assert property (@(posedge clk)
    (!porRstN || !manRstN) |=> (hitWayQ == '0 && !missQ && !hitDirtyQ));

  p_wt_clean_r7: assert property (@(posedge clk) disable iff (!porRstN)
    (wrEn && !copyBack && !fillEn && anyHit) |=>
      dirtyArr[$past(hitIdx)][$past(setIdx)] == $past(setDirty[hitIdx]));

  p_mru_r8: assert property (@(posedge clk) disable iff (!porRstN)
    doTouch |=> lruOldest(lruArr[$past(setIdx)]) != $past(touchWay));

  p_free_first_r9: assert property (@(posedge clk) disable iff (!porRstN)
    anyFree |-> !setValid[victim]);

endmodule

// File: rtl/vcache_vipt.sv
module vcache_vipt
  import vcache_pkg::*;
(
  input  logic                     clk,
  input  logic                     porRstN,
  input  logic                     manRstN,
  input  logic [VA_HI:OFFSET_LSB]  vAddr,
  input  logic [PA_W-1:TAG_LSB]    pAddr,
  input  logic                     rdEn,
  input  logic                     wrEn,
  input  logic [DATA_W-1:0]        wrData,
  input  logic                     copyBack,
  input  logic                     fillEn,
  input  logic [LINE_W-1:0]        fillLine,
  output logic [NUM_WAYS-1:0]      hitWay,
  output logic                     miss,
  output logic [DATA_W-1:0]        rdData,
  output logic [WAY_BITS-1:0]      victimWay,
  output logic                     hitDirty
);

  dpCtl_t                   ctl;
  logic [NUM_WAYS-1:0]      tagEq;
  logic [SET_BITS-1:0]      setIdx;
  logic [WORD_SEL_BITS-1:0] wordSel;

  assign setIdx  = vAddr[VA_HI:INDEX_LSB];
  assign wordSel = vAddr[INDEX_LSB-1:OFFSET_LSB];

  vcache_ctrl u_ctrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .manRstN  (manRstN),
    .setIdx   (setIdx),
    .rdEn     (rdEn),
    .wrEn     (wrEn),
    .fillEn   (fillEn),
    .copyBack (copyBack),
    .tagEq    (tagEq),
    .ctl      (ctl),
    .hitWayQ  (hitWay),
    .missQ    (miss),
    .victimQ  (victimWay),
    .hitDirtyQ(hitDirty)
  );

  vcache_datapath u_dp (
    .clk     (clk),
    .ctl     (ctl),
    .setIdx  (setIdx),
    .wordSel (wordSel),
    .tagIn   (pAddr),
    .fillLine(fillLine),
    .wrWord  (wrData),
    .tagEq   (tagEq),
    .rdData  (rdData)
  );

endmodule

// File: tb/tb_vcache_vipt.sv
module tb_vcache_vipt;

  localparam int CLK_PERIOD = 10;

  logic         clk = 1'b0;
  logic         porRstN, manRstN, rdEn, wrEn, copyBack, fillEn;
  logic [12:2]  vAddr;
  logic [28:10] pAddr;
  logic [31:0]  wrData, rdData;
  logic [255:0] fillLine;
  logic [3:0]   hitWay;
  logic         miss, hitDirty;
  logic [1:0]   victimWay;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  localparam logic [18:0] TAG_A = 19'h000A1, TAG_B = 19'h000B2, TAG_C = 19'h000C3,
                          TAG_D = 19'h000D4, TAG_E = 19'h000EE, TAG_F = 19'h001F0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vcache_vipt dut (.*);

  function automatic logic [255:0] mkLine(logic [31:0] base);
    logic [255:0] l;
    for (int k = 0; k < 8; k++) l[32*k +: 32] = base + 32'(k);
    return l;
  endfunction

  task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic idle();
    rdEn = 0; wrEn = 0; fillEn = 0;
  endtask

  task automatic doRead(logic [7:0] idx, logic [2:0] wd, logic [18:0] tag);
    @(negedge clk);
    vAddr = {idx, wd}; pAddr = tag; rdEn = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic doFill(logic [7:0] idx, logic [18:0] tag, logic [255:0] line);
    @(negedge clk);
    vAddr = {idx, 3'd0}; pAddr = tag; fillLine = line; fillEn = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic doWrite(logic [7:0] idx, logic [2:0] wd, logic [18:0] tag,
                         logic [31:0] d, logic cb);
    @(negedge clk);
    vAddr = {idx, wd}; pAddr = tag; wrData = d; copyBack = cb; wrEn = 1;
    @(negedge clk);
    idle();
  endtask

  task automatic expectLookup(string req, logic [3:0] hw, logic ms,
                              logic [31:0] dat, logic [1:0] vic, logic dty);
    chk(req, "hitWay", 64'(hitWay), 64'(hw));
    chk(req, "miss", 64'(miss), 64'(ms));
    chk(req, "rdData", 64'(rdData), 64'(dat));
    chk(req, "victimWay", 64'(victimWay), 64'(vic));
    chk(req, "hitDirty", 64'(hitDirty), 64'(dty));
  endtask

  task automatic tPowerOn();
    porRstN = 0; manRstN = 1; idle(); copyBack = 0;
    vAddr = '0; pAddr = '0; wrData = '0; fillLine = '0;
    repeat (3) @(negedge clk);
    porRstN = 1;
    expectLookup("R5 reset", 4'b0000, 0, 32'h0, 2'd0, 0);
    doRead(8'd5, 3'd0, TAG_A);
    expectLookup("R5 R9 empty set", 4'b0000, 1, 32'h0, 2'd0, 0);
  endtask

  task automatic tFillAll();
    doFill(8'd5, TAG_A, mkLine(32'hA000_0000));
    doRead(8'd5, 3'd3, TAG_A);
    expectLookup("R1 R4 first fill", 4'b0001, 0, 32'hA000_0003, 2'd1, 0);
    // R2: holds while rdEn is low
    repeat (2) @(negedge clk);
    chk("R2 hold", "rdData", 64'(rdData), 64'h0A000_0003);
    doRead(8'd6, 3'd3, TAG_A);
    chk("R1 other index", "miss", 64'(miss), 64'd1);
    doFill(8'd5, TAG_B, mkLine(32'hB000_0000));
    doFill(8'd5, TAG_C, mkLine(32'hC000_0000));
    doFill(8'd5, TAG_D, mkLine(32'hD000_0000));
    doRead(8'd5, 3'd7, TAG_B);
    expectLookup("R9 way1", 4'b0010, 0, 32'hB000_0007, 2'd0, 0);
    doRead(8'd5, 3'd0, TAG_C);
    chk("R9 way2", "hitWay", 64'(hitWay), 64'b0100);
    doRead(8'd5, 3'd5, TAG_D);
    expectLookup("R9 way3", 4'b1000, 0, 32'hD000_0005, 2'd0, 0);
  endtask

  task automatic tLru();
    // recency now 3,2,1,0 -> oldest 0; hits touch but B,C,D,A order fixed above
    doRead(8'd5, 3'd0, TAG_E);
    expectLookup("R8 oldest 0", 4'b0000, 1, 32'h0, 2'd0, 0);
    doRead(8'd5, 3'd0, TAG_A);
    doRead(8'd5, 3'd0, TAG_E);
    chk("R8 after touch 0", "victimWay", 64'(victimWay), 64'd1);
    doRead(8'd5, 3'd0, TAG_C);
    doRead(8'd5, 3'd0, TAG_B);
    doRead(8'd5, 3'd0, TAG_E);
    chk("R8 after touch 2,1", "victimWay", 64'(victimWay), 64'd3);
  endtask

  task automatic tWrites();
    doWrite(8'd5, 3'd6, TAG_D, 32'h1234_5678, 1);   // recency 3,1,2,0
    doWrite(8'd5, 3'd1, TAG_A, 32'hCAFE_0001, 0);   // recency 0,3,1,2
    doWrite(8'd5, 3'd0, TAG_E, 32'hDEAD_BEEF, 1);   // miss: no effect
    doRead(8'd5, 3'd0, TAG_E);
    chk("R11 lru kept", "victimWay", 64'(victimWay), 64'd2);
    doRead(8'd5, 3'd6, TAG_D);
    expectLookup("R7 copy-back", 4'b1000, 0, 32'h1234_5678, 2'd2, 1);
    doRead(8'd5, 3'd1, TAG_A);
    expectLookup("R7 write-through", 4'b0001, 0, 32'hCAFE_0001, 2'd2, 0);
    doRead(8'd5, 3'd0, TAG_A);
    chk("R11 data kept", "rdData", 64'(rdData), 64'h0A000_0000);
  endtask

  task automatic tManual();
    @(negedge clk); manRstN = 0;
    @(negedge clk); manRstN = 1;
    expectLookup("R6 outputs cleared", 4'b0000, 0, 32'h0, 2'd0, 0);
    doRead(8'd5, 3'd6, TAG_D);
    chk("R6 line kept", "hitWay", 64'(hitWay), 64'b1000);
    chk("R6 dirty kept", "hitDirty", 64'(hitDirty), 64'd1);
    chk("R6 data kept", "rdData", 64'(rdData), 64'h1234_5678);
  endtask

  task automatic tCollide();
    @(negedge clk);
    vAddr = {8'd9, 3'd2}; pAddr = TAG_F; fillLine = mkLine(32'hF000_0000);
    wrData = 32'h5555_AAAA; copyBack = 1; fillEn = 1; rdEn = 1; wrEn = 1;
    @(negedge clk);
    idle();
    expectLookup("R10 pre-fill view", 4'b0000, 1, 32'h0, 2'd0, 0);
    doRead(8'd9, 3'd2, TAG_F);
    expectLookup("R10 R4 fill wins", 4'b0001, 0, 32'hF000_0002, 2'd1, 0);
  endtask

  task automatic tPowerAgain();
    @(negedge clk); porRstN = 0;
    @(negedge clk); porRstN = 1;
    doRead(8'd5, 3'd6, TAG_D);
    expectLookup("R5 valid cleared", 4'b0000, 1, 32'h0, 2'd0, 0);
  endtask

  initial begin
    tPowerOn();
    tFillAll();
    tLru();
    tWrites();
    tManual();
    tCollide();
    tPowerAgain();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end

endmodule